// File: doc/BRIEF.md
# Per-Cluster Lock-Step Fetch and Branch Controller

This block is the control path of one cluster in a multicluster VLIW machine. There is no central program counter. Each cluster keeps its own PC and reads its own instruction stream from a local word-addressed instruction store. NOP slots are squeezed out of that stream, so bundles have different lengths. Each cluster finds its next PC by adding the length field of the bundle header it has just read. Several copies run in lock-step. They are joined by only three broadcast wires: a global stall (the OR of every copy's stall request), a branch predicate computed in one cluster, and a wake cue.

Each cluster holds private branch targets. A prepare operation writes a cluster-local address into a target register, so each cluster keeps its own address for the same logical destination. The replicated branch operation then redirects only when the broadcast predicate is high. Because every copy sees the same predicate in the same cycle, all copies move to the same logical multiop together. The compiler can also park a cluster for whole blocks. A sleep operation moves it from state `ST_RUN` to state `ST_DOZE`, where fetch is off and branches and predicates are ignored. The wake cue moves it from `ST_DOZE` back to `ST_RUN`, and the PC is loaded from a wake register that a prepare-wake operation filled earlier.

Top module: `clu_fetch_ctrl`

## Requirements
- R1: While reset is low, and right after it rises, the PC output equals the START_PC parameter, the cluster is awake (asleep_o=0) and fetch is enabled (imem_en_o=1).
- R2: In state ST_RUN with no global stall and no taken branch, the next PC is the current PC plus (header bits [1:0] + 1), so bundles are 1 to 4 words long.
- R3: A prepare bundle (header bits [3:2]=1) writes header bits [31:16] into the target register selected by header bits [5:4]. The PC still advances as in R2.
- R4: A branch bundle (header bits [3:2]=2) with pred_i high, in ST_RUN and with no stall, raises redirect_o in that same cycle. The next PC is then the selected target register.
- R5: A branch bundle with pred_i low falls through as in R2, and redirect_o stays low.
- R6: While gstall_i is high, the PC, the state and all target registers hold. No branch, sleep or wake takes effect.
- R7: stall_req_o follows this cluster's hazard_i in the same cycle. It does not depend on the other clusters.
- R8: A control bundle (header bits [3:2]=3) with bit 4 = 0 is a sleep. From the next cycle on, asleep_o=1 and imem_en_o=0, the PC holds, and pred_i is ignored.
- R9: A control bundle with bit 4 = 1 loads header bits [31:16] into the wake register. If wake_i is high in ST_DOZE with no stall, the next PC is that wake address and the cluster is awake.
- R10: If wake_i is high while the cluster is in ST_RUN, it has no effect, and the PC advances as in R2.
- R11: pred_i has no effect on a bundle that is not a branch bundle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hazard_i | input | 1 | Local stall cause in this cluster |
| gstall_i | input | 1 | Global stall (OR of all clusters' stall requests) |
| pred_i | input | 1 | Broadcast branch predicate, valid in the current cycle |
| wake_i | input | 1 | Broadcast wake cue at a block boundary |
| imem_rd_i | input | DW | Bundle header read at imem_addr_o |
| stall_req_o | output | 1 | This cluster's stall request to the global OR |
| imem_addr_o | output | AW | Current local PC / fetch address |
| imem_en_o | output | 1 | Fetch enable (low while asleep) |
| redirect_o | output | 1 | A taken branch is executing this cycle |
| asleep_o | output | 1 | Cluster is in ST_DOZE |

## Verification
Two instances with different code layouts share one stall OR and one predicate. The bench checks that they redirect in the same cycle, each to its own address. The two events that can fall in one cycle are a branch with a true predicate and a global stall raised by the other cluster. The bench lines both branch bundles up with the predicate high while the peer's hazard is raised, and checks that neither copy redirects and both PCs hold. One cycle later, with the stall gone, both copies must advance together. The bench does the same for a wake cue that arrives during a stall: the sleeping copy must stay asleep until the stall clears.

// File: rtl/fcx_pkg.sv
package fcx_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_PREP  = 2'd1,
        OP_BR    = 2'd2,
        OP_CTRL  = 2'd3
    } op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_DOZE = 1'b1
    } st_e;

    localparam int LEN_LSB = 0;
    localparam int OP_LSB  = 2;
    localparam int IDX_LSB = 4;
    localparam int SUB_BIT = 4;

endpackage

// File: rtl/fcx_decode.sv
module fcx_decode
    import fcx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic [DW-1:0] word_i,
    output logic [1:0]    len_code_o,
    output op_e           op_o,
    output logic [IW-1:0] idx_o,
    output logic          is_sleep_o,
    output logic          is_pwake_o,
    output logic [AW-1:0] tgt_o
);
    logic unused_bits;

    always_comb begin
        len_code_o = word_i[LEN_LSB +: 2];
        op_o       = op_e'(word_i[OP_LSB +: 2]);
        idx_o      = word_i[IDX_LSB +: IW];
        tgt_o      = word_i[DW-1 -: AW];
        is_sleep_o = (op_o == OP_CTRL) && !word_i[SUB_BIT];
        is_pwake_o = (op_o == OP_CTRL) &&  word_i[SUB_BIT];
    end

    assign unused_bits = ^word_i[DW-AW-1:IDX_LSB+IW];

endmodule

// File: rtl/fcx_pc_step.sv
module fcx_pc_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pc_i,
    input  logic [1:0]    len_code_i,
    output logic [AW-1:0] nxt_o
);
    logic [AW-1:0] words;

    always_comb begin
        words = AW'(len_code_i) + AW'(1);
        nxt_o = pc_i + words;
    end

endmodule

// File: rtl/fcx_tgt_bank.sv
module fcx_tgt_bank #(
    parameter int AW   = 16,
    parameter int NBTR = 4,
    localparam int IW  = (NBTR > 1) ? $clog2(NBTR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [AW-1:0] wdata_i,
    input  logic [IW-1:0] ridx_i,
    output logic [AW-1:0] rdata_o
);
    logic [AW-1:0] slot [NBTR];

    for (genvar g = 0; g < NBTR; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (we_i && (widx_i == IW'(g))) begin
                slot[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NBTR; k++) begin
            if (ridx_i == IW'(k)) rdata_o = slot[k];
        end
    end

endmodule

// File: rtl/clu_fetch_ctrl.sv
module clu_fetch_ctrl
    import fcx_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 32,
    parameter int          NBTR     = 4,
    parameter logic [15:0] START_PC = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hazard_i,
    input  logic          gstall_i,
    input  logic          pred_i,
    input  logic          wake_i,
    input  logic [DW-1:0] imem_rd_i,
    output logic          stall_req_o,
    output logic [AW-1:0] imem_addr_o,
    output logic          imem_en_o,
    output logic          redirect_o,
    output logic          asleep_o
);
    localparam int IW = (NBTR > 1) ? $clog2(NBTR) : 1;

    st_e           state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [AW-1:0] wake_q;

    logic [1:0]    len_code;
    op_e           op;
    logic [IW-1:0] idx;
    logic          is_sleep, is_pwake;
    logic [AW-1:0] tgt, seq_pc, btr_rd;

    logic          exec, take, prep_we, wake_we, sleep_go, wake_go;

    fcx_decode #(.AW(AW), .DW(DW), .IW(IW)) u_dec (
        .word_i     (imem_rd_i),
        .len_code_o (len_code),
        .op_o       (op),
        .idx_o      (idx),
        .is_sleep_o (is_sleep),
        .is_pwake_o (is_pwake),
        .tgt_o      (tgt)
    );

    fcx_pc_step #(.AW(AW)) u_step (
        .pc_i       (pc_q),
        .len_code_i (len_code),
        .nxt_o      (seq_pc)
    );

    fcx_tgt_bank #(.AW(AW), .NBTR(NBTR)) u_btr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prep_we),
        .widx_i  (idx),
        .wdata_i (tgt),
        .ridx_i  (idx),
        .rdata_o (btr_rd)
    );

    // bundle execution qualifiers
    always_comb begin
        exec     = (state_q == ST_RUN) && !gstall_i;
        take     = exec && (op == OP_BR) && pred_i;
        prep_we  = exec && (op == OP_PREP);
        wake_we  = exec && is_pwake;
        sleep_go = exec && is_sleep;
        wake_go  = (state_q == ST_DOZE) && !gstall_i && wake_i;
    end

    // next state and next PC
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_RUN: begin
                if (exec) pc_d = take ? btr_rd : seq_pc;
                if (sleep_go) state_d = ST_DOZE;
            end
            ST_DOZE: begin
                if (wake_go) begin
                    pc_d    = wake_q;
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= AW'(START_PC);
            wake_q  <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (wake_we) wake_q <= tgt;
        end
    end

    // outputs
    always_comb begin
        stall_req_o = hazard_i;
        imem_addr_o = pc_q;
        imem_en_o   = (state_q == ST_RUN);
        asleep_o    = (state_q == ST_DOZE);
        redirect_o  = take;
    end

endmodule

// File: rtl/fcx_check.sv
module fcx_check #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gstall_i,
    input logic          pred_i,
    input logic          wake_i,
    input logic [1:0]    len_code,
    input logic [AW-1:0] imem_addr_o,
    input logic          imem_en_o,
    input logic          redirect_o,
    input logic          asleep_o
);
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_en_o && !gstall_i && !redirect_o) |=>
        imem_addr_o == AW'($past(imem_addr_o) + AW'($past(len_code)) + AW'(1)));

    p_redir_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (pred_i && imem_en_o && !gstall_i));

    p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gstall_i |=> ($stable(imem_addr_o) && $stable(asleep_o)));

    p_doze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_o && !wake_i) |=> ($stable(imem_addr_o) && asleep_o));

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_o && wake_i && !gstall_i) |=> (!asleep_o && imem_en_o));

endmodule

bind clu_fetch_ctrl fcx_check #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gstall_i    (gstall_i),
    .pred_i      (pred_i),
    .wake_i      (wake_i),
    .len_code    (imem_rd_i[1:0]),
    .imem_addr_o (imem_addr_o),
    .imem_en_o   (imem_en_o),
    .redirect_o  (redirect_o),
    .asleep_o    (asleep_o)
);

// File: tb/sim_clu_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_clu_fetch_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NROW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h0 = 1'b0, h1 = 1'b0, pred = 1'b0, wake = 1'b0;
    logic [DW-1:0] rdA, rdB;
    logic [AW-1:0] addrA, addrB;
    logic sA, sB, enA, enB, rA, rB, s0, s1, gstall;
    logic [DW-1:0] memA [64];
    logic [DW-1:0] memB [64];
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign gstall = s0 | s1;
    assign rdA = memA[addrA[5:0]];
    assign rdB = memB[addrB[5:0]];

    clu_fetch_ctrl #(.AW(AW), .DW(DW), .NBTR(4), .START_PC(16'h0000)) u0 (
        .clk(clk), .rst_n(rst_n), .hazard_i(h0), .gstall_i(gstall), .pred_i(pred),
        .wake_i(wake), .imem_rd_i(rdA), .stall_req_o(s0), .imem_addr_o(addrA),
        .imem_en_o(enA), .redirect_o(rA), .asleep_o(sA));

    clu_fetch_ctrl #(.AW(AW), .DW(DW), .NBTR(4), .START_PC(16'h0100)) u1 (
        .clk(clk), .rst_n(rst_n), .hazard_i(h1), .gstall_i(gstall), .pred_i(pred),
        .wake_i(wake), .imem_rd_i(rdB), .stall_req_o(s1), .imem_addr_o(addrB),
        .imem_en_o(enB), .redirect_o(rB), .asleep_o(sB));

    // header: [31:16] target, [5:4] index/sub, [3:2] kind, [1:0] length-1
    function automatic logic [31:0] enc(input logic [15:0] t, input logic [1:0] ix,
                                        input logic [1:0] k, input int len);
        return {t, 10'd0, ix, k, 2'(len - 1)};
    endfunction

    // {h0,h1,pred,wake, addrA, addrB, redirA, redirB, asleepA}
    localparam logic [38:0] VEC [NROW] = '{
        {4'b0000, 16'd0,  16'd256, 3'b000},  // R1 start, R3 prep
        {4'b0100, 16'd2,  16'd257, 3'b000},  // R6 peer stall
        {4'b0000, 16'd2,  16'd257, 3'b000},  // R2 len 3 / len 1
        {4'b1010, 16'd5,  16'd258, 3'b000},  // R6 branch+stall same cycle
        {4'b0000, 16'd5,  16'd258, 3'b000},  // R5 pred low
        {4'b0010, 16'd6,  16'd259, 3'b110},  // R4 lock-step redirect
        {4'b0000, 16'd20, 16'd300, 3'b000},  // R9 prep wake
        {4'b0010, 16'd21, 16'd301, 3'b000},  // R8 sleep, R11 pred ignored
        {4'b0010, 16'd22, 16'd303, 3'b011},  // R8 asleep ignores pred
        {4'b1001, 16'd22, 16'd300, 3'b001},  // R6 wake under stall
        {4'b0001, 16'd22, 16'd300, 3'b001},  // R9 wake, R10 awake ignores
        {4'b0000, 16'd40, 16'd301, 3'b000},  // R2 len 4 / len 2
        {4'b0010, 16'd44, 16'd303, 3'b110},  // R4 redirect again
        {4'b0000, 16'd20, 16'd300, 3'b000}   // R4 own targets reached
    };
    localparam string RTAG [NROW] = '{"R1", "R6", "R2", "R6", "R5", "R4", "R9",
                                      "R8", "R8", "R6", "R10", "R2", "R4", "R4"};

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            memA[i] = enc(16'd0, 2'd0, 2'd0, 1);
            memB[i] = enc(16'd0, 2'd0, 2'd0, 1);
        end
        memA[0]  = enc(16'd20, 2'd1, 2'd1, 2);
        memA[2]  = enc(16'd0,  2'd0, 2'd0, 3);
        memA[5]  = enc(16'd0,  2'd1, 2'd2, 1);
        memA[6]  = enc(16'd0,  2'd1, 2'd2, 1);
        memA[20] = enc(16'd40, 2'd1, 2'd3, 1);
        memA[21] = enc(16'd0,  2'd0, 2'd3, 1);
        memA[40] = enc(16'd0,  2'd0, 2'd0, 4);
        memA[44] = enc(16'd0,  2'd1, 2'd2, 1);
        memB[0]  = enc(16'd300, 2'd1, 2'd1, 1);
        memB[2]  = enc(16'd0,   2'd1, 2'd2, 1);
        memB[3]  = enc(16'd0,   2'd1, 2'd2, 1);
        memB[45] = enc(16'd0,   2'd0, 2'd0, 2);
        memB[47] = enc(16'd0,   2'd1, 2'd2, 1);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is low
        chk("R1", {addrA, addrB, sA, enA, sB, enB}, {16'd0, 16'd256, 4'b0101});
        rst_n = 1'b1;

        for (int r = 0; r < NROW; r++) begin
            {h0, h1, pred, wake} = VEC[r][38:35];
            #1;
            chk(RTAG[r], {addrA, addrB, rA, rB, sA, enA},
                {VEC[r][34:3], VEC[r][2:0], ~VEC[r][0]});
            @(negedge clk);
        end

        // R7: stall request is per cluster; R6: both freeze
        {h0, h1, pred, wake} = 4'b1000;
        #1;
        chk("R7", {s0, s1}, 2'b10);
        @(negedge clk);
        chk("R6", {addrA, addrB}, {16'd21, 16'd301});
        h0 = 1'b0;
        h1 = 1'b1;
        #1;
        chk("R7", {s0, s1}, 2'b01);
        h1 = 1'b0;

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R1", {addrA, addrB, sA, enA, rA}, {16'd0, 16'd256, 3'b010});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", {addrA, addrB}, {16'd2, 16'd257});

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule